// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Unit with Glitch Filter

This block watches eight already-synchronized input pins and raises an interrupt when a pin changes level. Each pin has its own glitch filter, which can be switched off per pin. Each pin also has its own trigger selection: rising edge, falling edge, or either edge. Every pin keeps a sticky status bit, and the block drives the enable of an active-low open-drain interrupt line while any status bit is set.

The surrounding register front end supplies three inputs:

- the direction mask, where 1 means input;
- the per-pin interrupt enable mask;
- a one-cycle pulse that marks a read of the pin-state register.

This block holds the storage for three registers, written through a small write port:

| Address | Register | Reset value |
|---|---|---|
| 0x08 | rising-edge enable | 0x00 |
| 0x09 | falling-edge enable | 0x00 |
| 0x0A | filter enable | 0xFF |

The block returns the status byte, which the front end presents at address 0x07.

When both edge enables of a pin are clear, the pin interrupts on either edge. In that mode, the status bit also withdraws itself when the pin goes back to the level it had at the last state read. The level used for this comparison is captured on every state-read pulse. On the first clock after reset, it is seeded from the pin.

Top module: `irq_edge_unit`

## Requirements
- R1: After reset, the status byte is 0x00 and irq_pull is 0. The rising-edge and falling-edge enables reset to 0x00 and the filter enables reset to 0xFF.
- R2: A pin whose direction bit is 0 (output) or whose interrupt-enable bit is 0 never sets its status bit.
- R3: With rising = 0 and falling = 0, a level change in either direction sets the pin's status bit.
- R4: With rising = 1 and falling = 0, only a 0-to-1 change sets the status bit.
- R5: With rising = 0 and falling = 1, only a 1-to-0 change sets the status bit.
- R6: With rising = 1 and falling = 1, a change in either direction sets the status bit.
- R7: In the rising-only, falling-only and both-set modes, a set status bit stays set until a state_rd pulse, and that pulse clears it.
- R8: In the both-clear mode, a set status bit also clears when the filtered pin returns to the level captured at the last state_rd pulse. A change away from that level sets the bit again.
- R9: With a pin's filter bit at 1, a new level counts only once it has been sampled on FILT_CYCLES consecutive clock edges (default 50, which is 500 ns at 100 MHz). A shorter pulse is discarded.
- R10: With a pin's filter bit at 0, a level that is present for a single clock edge counts.
- R11: A qualifying edge in the same cycle as a state_rd pulse leaves the status bit set.
- R12: irq_pull is 1 exactly when at least one status bit is 1.
- R13: A write with cfg_we = 1 stores cfg_wdata into the register at address 0x08, 0x09 or 0x0A. Bit n of each register belongs to pin n.

Address 0x08 is the rising-edge enable, 0x09 the falling-edge enable and 0x0A the filter enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_sync | input | 8 | Synchronized pin levels, bit n = pin n |
| pin_is_input | input | 8 | Direction mask, 1 = input |
| pin_irq_en | input | 8 | Interrupt enable mask |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| state_rd | input | 1 | One-cycle pulse marking a read of the pin-state register |
| irq_status | output | 8 | Sticky interrupt status |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
The bench holds a filtered pulse for exactly one edge fewer than FILT_CYCLES, then for exactly FILT_CYCLES. A filter counter that is off by one would accept the short pulse or miss the long one.

In the both-clear mode, the bench reads the state register and then drives the pin away from and back to the captured level. A design that latched the reference at reset only, or never cleared by itself, would show a stuck bit. A design that set the bit on the return edge would also show a stuck bit.

The bench raises an edge in the same cycle as a read. A design that let the clear win would lose that interrupt. The bench also drives the wrong edge in the single-edge modes, where a swapped decode would set a bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int PIN_COUNT   = 8;
    localparam int CFG_ADDR_W  = 4;
    localparam int FILT_CYC    = 50;
    localparam logic [CFG_ADDR_W-1:0] ADDR_RISE = 4'h8;
    localparam logic [CFG_ADDR_W-1:0] ADDR_FALL = 4'h9;
    localparam logic [CFG_ADDR_W-1:0] ADDR_FILT = 4'hA;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int W  = irq_pkg::PIN_COUNT,
    parameter int AW = irq_pkg::CFG_ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rise_en,
    output logic [W-1:0]  fall_en,
    output logic [W-1:0]  filt_en
);
    typedef struct packed {
        logic [W-1:0] rise;
        logic [W-1:0] fall;
        logic [W-1:0] filt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == irq_pkg::ADDR_RISE) cfg_d.rise = wdata;
            if (addr == irq_pkg::ADDR_FALL) cfg_d.fall = wdata;
            if (addr == irq_pkg::ADDR_FILT) cfg_d.filt = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.rise <= '0;
            cfg_q.fall <= '0;
            cfg_q.filt <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rise_en = cfg_q.rise;
    assign fall_en = cfg_q.fall;
    assign filt_en = cfg_q.filt;

    assert_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == irq_pkg::ADDR_FILT) |=> filt_en == $past(wdata));
endmodule

// File: rtl/irq_pin_filter.sv
module irq_pin_filter #(
    parameter int CYC = irq_pkg::FILT_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic en,
    input  logic pin,
    output logic lvl,
    output logic acc
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        acc = 1'b0;
        if (load) begin
            s_d.lvl = pin;
            s_d.cnt = '0;
        end else if (pin == s_q.lvl) begin
            s_d.cnt = '0;
        end else if (!en || s_q.cnt == LAST) begin
            acc     = 1'b1;
            s_d.lvl = pin;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl = s_q.lvl;

    assert_short_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && pin != lvl && s_q.cnt != LAST) |=> $stable(lvl));

    assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !en) |=> lvl == $past(pin));
endmodule

// File: rtl/irq_pin_status.sv
module irq_pin_status #(
    parameter int W = irq_pkg::PIN_COUNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] arm,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic         rd,
    output logic [W-1:0] status,
    output logic         pull
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] refl;
        logic         pull;
    } st_t;

    st_t s_d, s_q;
    logic [W-1:0] new_lvl, both_mode, edge_ok, auto_clr, trig;

    always_comb begin
        new_lvl   = lvl ^ acc;
        both_mode = ~rise_en & ~fall_en;
        edge_ok   = (new_lvl & (rise_en | ~fall_en)) | (~new_lvl & (fall_en | ~rise_en));
        auto_clr  = both_mode & ~(new_lvl ^ s_q.refl);
        trig      = acc & arm & edge_ok & ~auto_clr;

        s_d      = s_q;
        s_d.stat = trig | (s_q.stat & ~{W{rd}} & ~auto_clr);
        if (load)    s_d.refl = seed;
        else if (rd) s_d.refl = lvl;
        s_d.pull = |s_d.stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status = s_q.stat;
    assign pull   = s_q.pull;

    assert_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status)) & ~$past(arm)) == '0);

    assert_rd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && acc == '0) |=> status == '0);
endmodule

// File: rtl/irq_edge_unit.sv
module irq_edge_unit #(
    parameter int NPIN        = irq_pkg::PIN_COUNT,
    parameter int AW          = irq_pkg::CFG_ADDR_W,
    parameter int FILT_CYCLES = irq_pkg::FILT_CYC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_sync,
    input  logic [NPIN-1:0] pin_is_input,
    input  logic [NPIN-1:0] pin_irq_en,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [NPIN-1:0] cfg_wdata,
    input  logic            state_rd,
    output logic [NPIN-1:0] irq_status,
    output logic            irq_pull
);
    logic primed_d, primed_q;
    logic [NPIN-1:0] rise_en, fall_en, filt_en, lvl, acc;

    always_comb primed_d = 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= primed_d;
    end

    irq_cfg_regs #(.W(NPIN), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rise_en(rise_en), .fall_en(fall_en), .filt_en(filt_en)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        irq_pin_filter #(.CYC(FILT_CYCLES)) u_flt (
            .clk(clk), .rst_n(rst_n), .load(!primed_q), .en(filt_en[i]),
            .pin(pin_sync[i]), .lvl(lvl[i]), .acc(acc[i])
        );
    end

    irq_pin_status #(.W(NPIN)) u_stat (
        .clk(clk), .rst_n(rst_n), .load(!primed_q), .seed(pin_sync),
        .lvl(lvl), .acc(acc), .arm(pin_is_input & pin_irq_en),
        .rise_en(rise_en), .fall_en(fall_en), .rd(state_rd),
        .status(irq_status), .pull(irq_pull)
    );

    assert_pull_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull == (|irq_status));
endmodule

// File: tb/irq_edge_unit_test.sv
module irq_edge_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_sync = '0, pin_is_input = '1, pin_irq_en = '0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       state_rd = 1'b0;
    logic [7:0] irq_status;
    logic       irq_pull;

    int compared = 0, mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    irq_edge_unit uut (
        .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .pin_is_input(pin_is_input),
        .pin_irq_en(pin_irq_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .state_rd(state_rd),
        .irq_status(irq_status), .irq_pull(irq_pull)
    );

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                compared++;
                if (irq_status !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: status actual %h expected %h", it.tag, irq_status, it.exp);
                end
                compared++;
                if (irq_pull !== (|it.exp)) begin
                    mismatched++;
                    $display("FAIL R12 (%s): irq_pull actual %b expected %b", it.tag, irq_pull, |it.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_st(input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic read_state();
        state_rd = 1'b1;
        step(1);
        state_rd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        expect_st(8'h00, "R1 reset state");

        // R2: outputs or disabled pins never interrupt (filter on by default)
        pin_is_input = 8'hF0; pin_irq_en = 8'h0F;
        pin_sync = 8'hFF; step(60);
        expect_st(8'h00, "R2 masked rise");
        pin_sync = 8'h00; step(60);
        expect_st(8'h00, "R2 masked fall");
        pin_is_input = 8'hFF; pin_irq_en = 8'hFF;

        // R10/R3: filter off, either-edge default mode
        cfg_write(4'hA, 8'h00);
        pin_sync = 8'h01; step(1);
        expect_st(8'h01, "R3 R10 single-edge accept");
        pin_sync = 8'h00; step(1);
        expect_st(8'h00, "R8 auto clear at reset level");

        pin_sync = 8'h01; step(1);
        expect_st(8'h01, "R3 rise");
        read_state();
        expect_st(8'h00, "R7 read clears");
        pin_sync = 8'h00; step(1);
        expect_st(8'h01, "R3 fall away from captured level");
        pin_sync = 8'h01; step(1);
        expect_st(8'h00, "R8 return to captured level");

        // R4: rising only
        cfg_write(4'h8, 8'hFF);
        read_state();
        pin_sync = 8'h00; step(1);
        expect_st(8'h00, "R4 fall ignored");
        pin_sync = 8'h01; step(1);
        expect_st(8'h01, "R4 rise sets");
        pin_sync = 8'h00; step(1);
        expect_st(8'h01, "R7 sticky without read");
        read_state();
        expect_st(8'h00, "R7 read clears");

        // R5: falling only
        cfg_write(4'h8, 8'h00);
        cfg_write(4'h9, 8'hFF);
        pin_sync = 8'h02; step(1);
        expect_st(8'h00, "R5 rise ignored");
        pin_sync = 8'h00; step(1);
        expect_st(8'h02, "R5 fall sets");
        read_state();

        // R6: both enables set
        cfg_write(4'h8, 8'hFF);
        pin_sync = 8'h80; step(1);
        expect_st(8'h80, "R6 rise");
        read_state();
        expect_st(8'h00, "R7 read clears");
        pin_sync = 8'h00; step(1);
        expect_st(8'h80, "R6 fall");
        read_state();

        // R11: edge and read in one cycle
        pin_sync = 8'h40; state_rd = 1'b1;
        step(1);
        state_rd = 1'b0;
        expect_st(8'h40, "R11 edge wins over read");
        read_state();
        expect_st(8'h00, "R7 read clears");

        // R9: filter on, 50-edge acceptance
        cfg_write(4'hA, 8'hFF);
        pin_sync = 8'h50; step(20);
        pin_sync = 8'h40; step(60);
        expect_st(8'h00, "R9 short pulse rejected");
        pin_sync = 8'h50; step(49);
        expect_st(8'h00, "R9 one edge short");
        step(1);
        expect_st(8'h10, "R9 accepted at limit");
        read_state();
        pin_sync = 8'h40; step(49);
        expect_st(8'h00, "R9 fall one edge short");
        step(1);
        expect_st(8'h10, "R9 fall accepted");
        read_state();
        expect_st(8'h00, "R7 read clears");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule